// File: doc/BRIEF.md
# Bus Write Activity Status Timer

This block produces the time-dependent flags of an external bus status word. A free-running tick counter advances once per clock. Every bus word write (a one-cycle pulse on `bus_wr`) arms three independent windows, one per timed status bit. Each window has its own delay before the bit shows and its own length. A write that lands while a window is still open lengthens that window instead of starting a new one, except for the fastest flag, which restarts on every write.

The status word is read combinationally on `st_rdata`. Bits 0, 4 and 5 come from the windows, judged against the current tick. Every other bit comes from a plain stored register that is loaded through `st_we`/`st_wdata`. All time comparisons use the sign of a wrapping difference, so windows stay correct when the counter rolls over. This holds as long as no window reaches further than half the counter range ahead of the current tick.

Top module: `wrbusy_status`

## Requirements
- R1: While reset is applied, and in the first cycle after the synchronised release, `tick` is 0 and all of `st_rdata` reads 0, which covers both the stored bits and the timed bits.
- R2: `tick` increases by one every clock after reset and wraps from all ones to zero.
- R3: A write sampled at tick t makes bit 5 read 1 from tick t+1 up to tick t+7. The bit reads 0 from t+8. Any later write restarts this window from its own tick.
- R4: A write at tick t while the bit 4 window is closed makes bit 4 read 1 for ticks t+8 up to t+15. The window is closed when its end is at or before t, or when it was never armed.
- R5: A write while the bit 4 window is open moves its end 16 ticks later and leaves its start unchanged.
- R6: A write at tick t while the bit 0 window is closed makes bit 0 read 1 for ticks t+24 up to t+47.
- R7: A write while the bit 0 window is open moves its end 24 ticks later and leaves its start unchanged.
- R8: A write that lands exactly on the tick where a window ends treats that window as closed. It therefore starts a fresh window and does not extend the old one.
- R9: Windows that straddle the counter rollover show the same timing as windows that do not.
- R10: Every status bit other than 0, 4 and 5 returns the value last written through `st_we`, from the cycle after the write. Values written to bit positions 0, 4 and 5 have no effect on what is read there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | One-cycle pulse per bus word write |
| st_we | input | 1 | Load enable for the stored status bits |
| st_wdata | input | DW | Value for the stored status bits |
| st_rdata | output | DW | Composed status word |
| tick | output | TW | Current value of the free-running tick counter |

## Verification
The bench targets the exact tick on which each window closes. It writes at the very tick a window ends, so a design that compares with the wrong sign or strictness would extend a finished window rather than start a new one. Writes spaced inside open windows expose a design that restarts bit 4 or bit 0 where it should only push the end out, or one that moves the start as well. The bench also runs writes across counter rollover, where a design that compares unsigned would drop or stretch the windows. Stored-bit loads that carry ones in positions 0, 4 and 5 catch a design that lets those positions leak through.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  localparam int NUM_WIN = 3;
  // index 0: fast flag, 1: middle flag, 2: slow flag
  localparam int WIN_POS      [NUM_WIN] = '{5, 4, 0};
  localparam int WIN_ON       [NUM_WIN] = '{0, 8, 24};
  localparam int WIN_IDLE_OFF [NUM_WIN] = '{8, 16, 48};
  localparam int WIN_EXT      [NUM_WIN] = '{8, 16, 24};
  localparam bit WIN_RESTART  [NUM_WIN] = '{1'b1, 1'b0, 1'b0};
endpackage

// File: rtl/wbs_rst_sync.sv
`timescale 1ns/1ps
module wbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wbs_tick.sv
`timescale 1ns/1ps
module wbs_tick #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick
);
  logic [TW-1:0] tick_d;

  always_comb begin
    tick_d = tick + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick_d;
  end
endmodule

// File: rtl/wbs_store_reg.sv
`timescale 1ns/1ps
module wbs_store_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/wbs_window.sv
`timescale 1ns/1ps
module wbs_window #(
  parameter int TW       = 16,
  parameter int ON_DLY   = 8,
  parameter int IDLE_OFF = 16,
  parameter int EXT      = 16,
  parameter bit RESTART  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now,
  input  logic          wr,
  output logic          shown
);
  localparam logic [TW-1:0] ON_C   = ON_DLY[TW-1:0];
  localparam logic [TW-1:0] IDLE_C = IDLE_OFF[TW-1:0];
  localparam logic [TW-1:0] EXT_C  = EXT[TW-1:0];

  logic [TW-1:0] on_q, off_q, on_d, off_d;
  logic [TW-1:0] d_on, d_off;
  logic          live_q, live_d;
  logic          reached, started, open_win, upd_en;

  always_comb begin
    // sign of the wrapping difference decides order
    d_on     = now - on_q;
    d_off    = now - off_q;
    started  = ~d_on[TW-1];
    reached  = ~d_off[TW-1];
    open_win = live_q & ~reached;
    shown    = open_win & started;

    on_d   = on_q;
    off_d  = off_q;
    live_d = live_q;
    upd_en = 1'b0;
    if (wr) begin
      upd_en = 1'b1;
      live_d = 1'b1;
      if (RESTART || !open_win) begin
        on_d  = now + ON_C;
        off_d = now + IDLE_C;
      end else begin
        off_d = off_q + EXT_C;
      end
    end else if (live_q && reached) begin
      upd_en = 1'b1;
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      off_q  <= '0;
      live_q <= 1'b0;
    end else if (upd_en) begin
      on_q   <= on_d;
      off_q  <= off_d;
      live_q <= live_d;
    end
  end
endmodule

// File: rtl/wrbusy_status.sv
`timescale 1ns/1ps
module wrbusy_status
  import wbs_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          st_we,
  input  logic [DW-1:0] st_wdata,
  output logic [DW-1:0] st_rdata,
  output logic [TW-1:0] tick
);
  logic               rst_sync_n;
  logic [DW-1:0]      stored;
  logic [NUM_WIN-1:0] shown;

  wbs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wbs_tick #(.TW(TW)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  wbs_store_reg #(.DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (st_we),
    .wdata (st_wdata),
    .q     (stored)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    wbs_window #(
      .TW       (TW),
      .ON_DLY   (WIN_ON[g]),
      .IDLE_OFF (WIN_IDLE_OFF[g]),
      .EXT      (WIN_EXT[g]),
      .RESTART  (WIN_RESTART[g])
    ) u_win (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .now   (tick),
      .wr    (bus_wr),
      .shown (shown[g])
    );
  end

  always_comb begin
    st_rdata = stored;
    for (int i = 0; i < NUM_WIN; i++) st_rdata[WIN_POS[i]] = shown[i];
  end
endmodule

// File: rtl/wbs_checker.sv
`timescale 1ns/1ps
module wbs_checker
  import wbs_pkg::*;
#(
  parameter int TW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_sync_n,
  input logic          bus_wr,
  input logic          st_we,
  input logic [DW-1:0] st_wdata,
  input logic [DW-1:0] st_rdata,
  input logic [TW-1:0] tick
);
  function automatic logic [DW-1:0] timed_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_WIN; i++) m[WIN_POS[i]] = 1'b1;
    return m;
  endfunction
  localparam logic [DW-1:0] TMASK = timed_mask();

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (tick == '0 && st_rdata == '0));

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (tick == $past(tick) + TW'(1)));

  assert_fast_flag_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_wr |=> st_rdata[WIN_POS[0]]);

  assert_stored_bits_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    st_we |=> ((st_rdata & ~TMASK) == ($past(st_wdata) & ~TMASK)));
endmodule

bind wrbusy_status wbs_checker #(.TW(TW), .DW(DW)) u_wbs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .st_we      (st_we),
  .st_wdata   (st_wdata),
  .st_rdata   (st_rdata),
  .tick       (tick)
);

// File: tb/wrbusy_status_bench.sv
`timescale 1ns/1ps
module wrbusy_status_bench;
  localparam int TW = 12;
  localparam int DW = 32;
  localparam longint WRAP = 64'd1 << TW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic          st_we;
  logic [DW-1:0] st_wdata;
  logic [DW-1:0] st_rdata;
  logic [TW-1:0] tick;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wrbusy_status #(.TW(TW), .DW(DW)) u_wrbusy_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .st_we    (st_we),
    .st_wdata (st_wdata),
    .st_rdata (st_rdata),
    .tick     (tick)
  );

  // reference model in unbounded time
  longint t_now = 0;
  longint on5 = 0, off5 = 0, on4 = 0, off4 = 0, on0 = 0, off0 = 0;
  logic [DW-1:0] stored_m = '0;
  string tag4 = "R4";
  string tag0 = "R6";
  string ph   = "";
  localparam logic [DW-1:0] TMASK = 32'h0000_0031;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(input longint on_t, input longint off_t);
    return (on_t <= t_now) && (t_now < off_t);
  endfunction

  task automatic step(input bit w, input bit sw, input logic [DW-1:0] swd);
    bit e5, e4, e0;
    e5 = in_win(on5, off5);
    e4 = in_win(on4, off4);
    e0 = in_win(on0, off0);
    chk(tick == TW'(t_now % WRAP), {"R2", ph}, "tick", tick, t_now % WRAP);
    chk(st_rdata[5] == e5, {"R3", ph}, "bit5", st_rdata[5], e5);
    chk(st_rdata[4] == e4, {tag4, ph}, "bit4", st_rdata[4], e4);
    chk(st_rdata[0] == e0, {tag0, ph}, "bit0", st_rdata[0], e0);
    chk((st_rdata & ~TMASK) == (stored_m & ~TMASK), "R10", "stored",
        st_rdata & ~TMASK, stored_m & ~TMASK);
    bus_wr   = w;
    st_we    = sw;
    st_wdata = swd;
    if (w) begin
      on5 = t_now; off5 = t_now + 8;
      if (off4 <= t_now) begin on4 = t_now + 8; off4 = t_now + 16; tag4 = "R4"; end
      else begin off4 = off4 + 16; tag4 = "R5"; end
      if (off0 <= t_now) begin on0 = t_now + 24; off0 = t_now + 48; tag0 = "R6"; end
      else begin off0 = off0 + 24; tag0 = "R7"; end
    end
    if (sw) stored_m = swd;
    @(posedge clk);
    t_now++;
    @(negedge clk);
    bus_wr = 1'b0;
    st_we  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", t_now);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n    = 1'b0;
    bus_wr   = 1'b0;
    st_we    = 1'b0;
    st_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held clear during reset
    chk(tick == '0, "R1", "tick in reset", tick, 0);
    chk(st_rdata == '0, "R1", "status in reset", st_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tick == '0, "R1", "tick after release", tick, 0);
    chk(st_rdata == '0, "R1", "status after release", st_rdata, 0);

    // R10: stored bits, including ones at timed positions
    step(1'b0, 1'b1, 32'hFFFF_FFFF);
    step(1'b0, 1'b1, 32'hA5A5_5A5A);
    step(1'b0, 1'b1, 32'h0000_0031);
    idle(2);

    // single write
    step(1'b1, 1'b0, '0);
    idle(60);
    // two writes inside open windows (R5, R7)
    step(1'b1, 1'b0, '0);
    idle(2);
    step(1'b1, 1'b0, '0);
    idle(80);
    step(1'b1, 1'b0, '0);
    idle(10);
    step(1'b1, 1'b0, '0);
    idle(90);
    // burst of back-to-back writes
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0);
    idle(300);

    // R8: writes exactly at window ends
    ph = " R8";
    step(1'b1, 1'b0, '0);
    idle(15);
    step(1'b1, 1'b0, '0);
    idle(100);
    step(1'b1, 1'b0, '0);
    idle(47);
    step(1'b1, 1'b0, '0);
    idle(7);
    step(1'b1, 1'b0, '0);
    idle(120);
    ph = "";

    // R9: windows across rollover
    while ((t_now % WRAP) != (WRAP - 20)) step(1'b0, 1'b0, '0);
    ph = " R9";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, '0);
      idle(4);
    end
    idle(150);
    while ((t_now % WRAP) != (WRAP - 9)) step(1'b0, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    idle(80);
    ph = "";

    // sparse pseudo-random writes and stored-bit loads
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[4:0] == 5'd0, lfsr[9:5] == 5'd3, {lfsr, ~lfsr});
    end
    idle(60);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule